// File: doc/BRIEF.md
# T1 Loopback Code Generator and Detector

This block sits in the transmit and receive bit paths of a T1 line interface and handles in-band line loopback signalling. On the transmit side a small control word picks, frame by frame, what fills the 192 payload bits of each 193-bit frame. The choices are the system data, the received payload (payload loopback), a repeating loop-up code or a repeating loop-down code. The framing bit position is never replaced, so framing and CRC are regenerated by the framer in each direction.

On the receive side two detectors watch the line bit stream, one for the 5-bit loop-up code `00001` and one for the 3-bit loop-down code `001`. A detector compares every non-framing bit with the bit one code period earlier and counts the mismatches and the ones in each frame. A frame qualifies when the mismatches stay within a small allowance and the ones count is close to what the code implies. After five consecutive qualifying frames the detect flag rises. It drops after the first frame that does not qualify. Deciding how many seconds a code must persist is left to host software.

Both directions are bit-serial, one bit per clock, and each has a strobe that marks its framing-bit cycle.

Top module: `t1_loopback_codec`

## Requirements
- R1: With control bits [1:0] = 00, every payload bit on `tx_bit` equals `sys_bit` in the same cycle.
- R2: With control bits [1:0] = 01, every payload bit on `tx_bit` equals `rx_pay_bit` in the same cycle (payload loopback).
- R3: With control bits [1:0] = 10, payload bits carry the loop-up code. Counting payload bits since reset as k = 0, 1, 2, …, the bit is 1 when k mod 5 = 4 and 0 otherwise. The count skips framing-bit cycles and runs on across frames and modes.
- R4: With control bits [1:0] = 11, payload bits carry the loop-down code, using the same count k: the bit is 1 when k mod 3 = 2 and 0 otherwise.
- R5: Control bits [7:2] have no effect on the selection.
- R6: In the cycle where `tx_frame_bit` is high, `tx_bit` equals `sys_bit` in every mode.
- R7: The control word is sampled only in the `tx_frame_bit` cycle. It governs the payload bits that follow until the next strobe, and a change in between has no effect.
- R8: While `rst_n` is low, `tx_bit` equals `sys_bit`.
- R9: A frame is the 192 non-framing bits between two `rx_frame_bit` strobes. It qualifies for a code of period P when no more than 6 bits differ from the bit P positions earlier (framing bits excluded) and its ones count lies within 192/P ± 8. The flag for that code rises in the cycle after the strobe that closes the fifth consecutive qualifying frame. The two flags are never high together.
- R10: Detection succeeds for a framed code, where the framing bit is not part of the pattern, and for an unframed code, where the pattern also runs through the framing-bit position.
- R11: Detection succeeds with one flipped bit in each frame.
- R12: Random data and all-ones data never raise a flag. A raised flag drops in the cycle after the strobe that closes the first non-qualifying frame.
- R13: Both detect flags are low during reset and right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| lb_ctrl | input | 8 | Loopback control word; only bits [1:0] select the source |
| tx_frame_bit | input | 1 | High in the transmit framing-bit cycle |
| sys_bit | input | 1 | System transmit data bit |
| rx_pay_bit | input | 1 | Received payload bit aligned to the transmit stream |
| tx_bit | output | 1 | Transmit data bit toward the framer |
| rx_frame_bit | input | 1 | High in the receive framing-bit cycle |
| rx_bit | input | 1 | Received line data bit |
| loopup_det | output | 1 | Loop-up code (`00001`) detected |
| loopdown_det | output | 1 | Loop-down code (`001`) detected |

## Verification
`tx_bit` is a combinational choice among same-cycle inputs. The bench therefore drives each transmit bit after a falling edge and compares one time unit later, in the same cycle. A control word takes effect on the first payload bit after the strobe cycle that samples it, so the bench changes the word mid-frame and expects the old selection to hold. The detect flags move only at the rising edge that ends a receive strobe cycle, and that edge judges the frame just finished. The bench checks both flags at the first falling edge after each strobe and expects the flag to rise at the sixth strobe of a run of code frames: the first strobe closes the preceding data.

// File: rtl/t1_lb_pkg.sv
package t1_lb_pkg;

   // Transmit source selection, decoded from the two low control bits.
   typedef enum logic [1:0] {
      LB_PASS = 2'b00,
      LB_LOOP = 2'b01,
      LB_UP   = 2'b10,
      LB_DOWN = 2'b11
   } lb_mode_e;

endpackage

// File: rtl/lb_code_gen.sv
// Free-running generator for a repeating 0...01 code of length PERIOD.
// The phase advances only on payload bits.
module lb_code_gen #(
   parameter int PERIOD = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   output logic code_bit
);
   localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("lb_code_gen: PERIOD must be at least 2");
      end
   endgenerate

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (advance) begin
         phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
   end

   assign code_bit = (phase_q == LAST);

endmodule

// File: rtl/lb_code_det.sv
// Error-tolerant detector for a repeating code of length PERIOD. Each
// frame's non-framing bits are compared with the bit PERIOD positions
// earlier, and the ones are counted. Qualifying frames build a run.
module lb_code_det #(
   parameter int PERIOD   = 3,
   parameter int PAY_BITS = 192,
   parameter int MAX_MISM = 6,
   parameter int ONES_TOL = 8,
   parameter int PERSIST  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_strobe,
   input  logic line_bit,
   output logic detected
);
   localparam int CW        = $clog2(PAY_BITS + 1);
   localparam int RW        = $clog2(PERSIST + 1);
   localparam int ONES_NOM  = PAY_BITS / PERIOD;
   localparam int ONES_LO_I = (ONES_NOM > ONES_TOL) ? ONES_NOM - ONES_TOL : 0;
   localparam logic [CW-1:0] MISM_LIM = CW'(MAX_MISM);
   localparam logic [CW-1:0] ONES_LO  = CW'(ONES_LO_I);
   localparam logic [CW-1:0] ONES_HI  = CW'(ONES_NOM + ONES_TOL);
   localparam logic [CW-1:0] CNT_SAT  = '1;
   localparam logic [RW-1:0] RUN_MAX  = RW'(PERSIST);
   localparam logic [RW-1:0] RUN_SET  = RW'(PERSIST - 1);

   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("lb_code_det: PERIOD must be at least 2");
      end
      if (PERSIST < 1) begin : g_bad_persist
         $error("lb_code_det: PERSIST must be at least 1");
      end
      if (MAX_MISM >= PAY_BITS) begin : g_bad_mism
         $error("lb_code_det: MAX_MISM must be below PAY_BITS");
      end
   endgenerate

   logic [PERIOD-1:0] hist_q;
   logic [CW-1:0]     mism_q;
   logic [CW-1:0]     ones_q;
   logic [RW-1:0]     run_q;
   logic              miss;
   logic              qualify;

   assign miss    = line_bit ^ hist_q[PERIOD-1];
   assign qualify = (mism_q <= MISM_LIM) && (ones_q >= ONES_LO) && (ones_q <= ONES_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q   <= '0;
         mism_q   <= '0;
         ones_q   <= '0;
         run_q    <= '0;
         detected <= 1'b0;
      end else if (frame_strobe) begin
         // Judge the frame that just ended, then open a new window.
         mism_q <= '0;
         ones_q <= '0;
         if (qualify) begin
            run_q    <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
            detected <= (run_q >= RUN_SET);
         end else begin
            run_q    <= '0;
            detected <= 1'b0;
         end
      end else begin
         hist_q <= {hist_q[PERIOD-2:0], line_bit};
         if (miss && (mism_q != CNT_SAT)) begin
            mism_q <= mism_q + 1'b1;
         end
         if (line_bit && (ones_q != CNT_SAT)) begin
            ones_q <= ones_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/t1_loopback_codec.sv
module t1_loopback_codec
   import t1_lb_pkg::*;
#(
   parameter int CTRL_W    = 8,
   parameter int PAY_BITS  = 192,
   parameter int UP_PERIOD = 5,
   parameter int DN_PERIOD = 3,
   parameter int MAX_MISM  = 6,
   parameter int ONES_TOL  = 8,
   parameter int PERSIST   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] lb_ctrl,
   input  logic              tx_frame_bit,
   input  logic              sys_bit,
   input  logic              rx_pay_bit,
   output logic              tx_bit,
   input  logic              rx_frame_bit,
   input  logic              rx_bit,
   output logic              loopup_det,
   output logic              loopdown_det
);
   // The two ones-count windows must not overlap, or one frame could
   // qualify for both codes.
   localparam int DN_ONES_LO = PAY_BITS / DN_PERIOD - ONES_TOL;
   localparam int UP_ONES_HI = PAY_BITS / UP_PERIOD + ONES_TOL;

   generate
      if (CTRL_W < 2) begin : g_bad_ctrl
         $error("t1_loopback_codec: CTRL_W must be at least 2");
      end
      if (UP_PERIOD <= DN_PERIOD) begin : g_bad_periods
         $error("t1_loopback_codec: UP_PERIOD must exceed DN_PERIOD");
      end
      if (DN_ONES_LO <= UP_ONES_HI) begin : g_bad_windows
         $error("t1_loopback_codec: ones windows overlap, reduce ONES_TOL");
      end
   endgenerate

   lb_mode_e mode_q;
   logic     up_bit;
   logic     dn_bit;

   // Selection is latched once per frame, at the framing bit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= LB_PASS;
      end else if (tx_frame_bit) begin
         mode_q <= lb_mode_e'(lb_ctrl[1:0]);
      end
   end

   lb_code_gen #(.PERIOD(UP_PERIOD)) i_gen_up (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (~tx_frame_bit),
      .code_bit (up_bit)
   );

   lb_code_gen #(.PERIOD(DN_PERIOD)) i_gen_dn (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (~tx_frame_bit),
      .code_bit (dn_bit)
   );

   always_comb begin
      if (!rst_n || tx_frame_bit) begin
         tx_bit = sys_bit;
      end else begin
         unique case (mode_q)
            LB_PASS: tx_bit = sys_bit;
            LB_LOOP: tx_bit = rx_pay_bit;
            LB_UP:   tx_bit = up_bit;
            LB_DOWN: tx_bit = dn_bit;
            default: tx_bit = sys_bit;
         endcase
      end
   end

   lb_code_det #(
      .PERIOD   (UP_PERIOD),
      .PAY_BITS (PAY_BITS),
      .MAX_MISM (MAX_MISM),
      .ONES_TOL (ONES_TOL),
      .PERSIST  (PERSIST)
   ) i_det_up (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_strobe (rx_frame_bit),
      .line_bit     (rx_bit),
      .detected     (loopup_det)
   );

   lb_code_det #(
      .PERIOD   (DN_PERIOD),
      .PAY_BITS (PAY_BITS),
      .MAX_MISM (MAX_MISM),
      .ONES_TOL (ONES_TOL),
      .PERSIST  (PERSIST)
   ) i_det_dn (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_strobe (rx_frame_bit),
      .line_bit     (rx_bit),
      .detected     (loopdown_det)
   );

endmodule

// File: rtl/t1_loopback_codec_chk.sv
module t1_loopback_codec_chk
   import t1_lb_pkg::*;
(
   input logic     clk,
   input logic     rst_n,
   input logic     tx_frame_bit,
   input logic     sys_bit,
   input logic     tx_bit,
   input logic     rx_frame_bit,
   input logic     loopup_det,
   input logic     loopdown_det,
   input lb_mode_e mode_q
);

   // R6: the framing-bit slot always carries system data.
   a_r6_frame_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
      tx_frame_bit |-> (tx_bit == sys_bit));

   // R8: data passes straight through while reset is held.
   a_r8_reset_passthrough: assert property (@(posedge clk)
      !rst_n |-> (tx_bit == sys_bit));

   // R13: flags are low in the cycle after any reset cycle.
   a_r13_flags_low_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!loopup_det && !loopdown_det));

   // R7: the selection only moves after a framing strobe.
   a_r7_mode_held_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_frame_bit |=> $stable(mode_q));

   // R9: a flag rises only at the edge ending a receive strobe cycle.
   a_r9_up_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loopup_det) |-> $past(rx_frame_bit));

   a_r9_dn_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loopdown_det) |-> $past(rx_frame_bit));

   // R9: the two codes never qualify together.
   a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(loopup_det && loopdown_det));

   // R12: a flag drops only at the edge ending a receive strobe cycle.
   a_r12_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(loopup_det) || $fell(loopdown_det)) |-> $past(rx_frame_bit));

endmodule

bind t1_loopback_codec t1_loopback_codec_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_frame_bit (tx_frame_bit),
   .sys_bit      (sys_bit),
   .tx_bit       (tx_bit),
   .rx_frame_bit (rx_frame_bit),
   .loopup_det   (loopup_det),
   .loopdown_det (loopdown_det),
   .mode_q       (mode_q)
);

// File: tb/test_t1_loopback_codec.sv
module test_t1_loopback_codec;
   localparam int CLK_P = 10;
   localparam int PAY   = 192;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] lb_ctrl;
   logic       tx_frame_bit;
   logic       sys_bit;
   logic       rx_pay_bit;
   logic       tx_bit;
   logic       rx_frame_bit;
   logic       rx_bit;
   logic       loopup_det;
   logic       loopdown_det;

   int         n_checks = 0;
   int         n_fails  = 0;
   bit         done     = 1'b0;
   int         k;             // payload bits sent since reset
   int         rxph     = 0;  // receive code phase
   logic [15:0] lfsr    = 16'hACE1;

   always #(CLK_P/2) clk = ~clk;

   t1_loopback_codec i_t1_loopback_codec (
      .clk          (clk),
      .rst_n        (rst_n),
      .lb_ctrl      (lb_ctrl),
      .tx_frame_bit (tx_frame_bit),
      .sys_bit      (sys_bit),
      .rx_pay_bit   (rx_pay_bit),
      .tx_bit       (tx_bit),
      .rx_frame_bit (rx_frame_bit),
      .rx_bit       (rx_bit),
      .loopup_det   (loopup_det),
      .loopdown_det (loopdown_det)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)             k <= 0;
      else if (!tx_frame_bit) k <= k + 1;
   end

   function automatic logic rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
         $finish;
      end
   endtask

   // R8, R13: data passes and flags stay low while reset is held.
   task automatic t_reset();
      int bad = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         lb_ctrl      = 8'h02;
         tx_frame_bit = (i % 4 == 0);
         sys_bit      = rnd();
         rx_pay_bit   = ~sys_bit;
         #1;
         if (tx_bit !== sys_bit) bad++;
      end
      check(bad == 0, "R8", "reset passthrough mismatches", bad, 0);
      check(!loopup_det && !loopdown_det, "R13", "flags in reset",
            {loopup_det, loopdown_det}, 0);
      @(negedge clk);
      tx_frame_bit = 1'b0;
      rst_n        = 1'b1;
      #1;
      check(!loopup_det && !loopdown_det, "R13", "flags after reset",
            {loopup_det, loopdown_det}, 0);
   endtask

   // One transmit frame: strobe cycle, then 192 payload bits.
   // exp_mode 0 pass, 1 loopback, 2 up code, 3 down code.
   task automatic tx_frame(input logic [7:0] ctrl, input logic [7:0] ctrl_mid,
                           input int exp_mode, input string req);
      int   bad = 0;
      int   first_act = 0;
      int   first_exp = 0;
      logic e;
      @(negedge clk);
      lb_ctrl      = ctrl;
      tx_frame_bit = 1'b1;
      sys_bit      = rnd();
      rx_pay_bit   = ~sys_bit;
      #1;
      check(tx_bit === sys_bit, "R6", "framing slot bit", tx_bit, sys_bit);
      for (int p = 0; p < PAY; p++) begin
         @(negedge clk);
         tx_frame_bit = 1'b0;
         if (p == 5) lb_ctrl = ctrl_mid;
         sys_bit    = rnd();
         rx_pay_bit = rnd();
         #1;
         case (exp_mode)
            0:       e = sys_bit;
            1:       e = rx_pay_bit;
            2:       e = (k % 5 == 4);
            default: e = (k % 3 == 2);
         endcase
         if (tx_bit !== e) begin
            if (bad == 0) begin
               first_act = tx_bit;
               first_exp = e;
            end
            bad++;
         end
      end
      check(bad == 0, req, "payload bit mismatch (first shown)", first_act, first_exp);
   endtask

   task automatic t_tx_modes();
      tx_frame(8'h00, 8'h00, 0, "R1");
      tx_frame(8'h01, 8'h01, 1, "R2");
      tx_frame(8'h02, 8'h02, 2, "R3");
      tx_frame(8'h02, 8'h02, 2, "R3");   // phase continues across frames
      tx_frame(8'h03, 8'h03, 3, "R4");
      tx_frame(8'h03, 8'h03, 3, "R4");
   endtask

   task automatic t_ctrl_upper_bits();
      tx_frame(8'hFE, 8'hFE, 2, "R5");
      tx_frame(8'hFD, 8'hFD, 1, "R5");
      tx_frame(8'hFC, 8'hFC, 0, "R5");
   endtask

   task automatic t_ctrl_mid_frame();
      tx_frame(8'h03, 8'h01, 3, "R7");   // change after strobe ignored
      tx_frame(8'h01, 8'h01, 1, "R7");   // applies at next strobe
   endtask

   // kind 0 down code, 1 up code, 2 random, 3 all ones.
   function automatic logic rx_gen(input int kind);
      logic b;
      case (kind)
         0:       begin b = (rxph % 3 == 2); rxph++; end
         1:       begin b = (rxph % 5 == 4); rxph++; end
         2:       b = rnd();
         default: b = 1'b1;
      endcase
      return b;
   endfunction

   // One receive frame. The flags are checked after its strobe,
   // which judges the frame sent before it.
   task automatic rx_frame(input int kind, input bit framed, input int errpos,
                           input logic exp_up, input logic exp_dn, input string req);
      @(negedge clk);
      rx_frame_bit = 1'b1;
      rx_bit       = framed ? 1'b1 : rx_gen(kind);
      for (int p = 0; p < PAY; p++) begin
         @(negedge clk);
         if (p == 0) begin
            check(loopup_det === exp_up, req, "loop-up flag", loopup_det, exp_up);
            check(loopdown_det === exp_dn, req, "loop-down flag", loopdown_det, exp_dn);
         end
         rx_frame_bit = 1'b0;
         rx_bit       = rx_gen(kind);
         if (p == errpos) rx_bit = ~rx_bit;
      end
   endtask

   task automatic t_rx_down_framed();
      for (int i = 1; i <= 6; i++) rx_frame(0, 1'b1, -1, 1'b0, (i == 6), "R9");
   endtask

   task automatic t_rx_clear_and_up_unframed();
      rx_frame(2, 1'b1, -1, 1'b0, 1'b1, "R12");   // judges last code frame
      for (int i = 1; i <= 6; i++) rx_frame(1, 1'b0, -1, (i == 6), 1'b0, "R10");
   endtask

   task automatic t_rx_errors();
      for (int i = 1; i <= 6; i++)
         rx_frame(0, 1'b1, (i == 1) ? -1 : 100, (i == 1), (i == 6), "R11");
   endtask

   task automatic t_rx_all_ones();
      rx_frame(3, 1'b1, -1, 1'b0, 1'b1, "R12");
      for (int i = 2; i <= 5; i++) rx_frame(3, 1'b1, -1, 1'b0, 1'b0, "R12");
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      rst_n        = 1'b0;
      lb_ctrl      = 8'h00;
      tx_frame_bit = 1'b0;
      sys_bit      = 1'b0;
      rx_pay_bit   = 1'b0;
      rx_frame_bit = 1'b0;
      rx_bit       = 1'b0;
      t_reset();
      t_tx_modes();
      t_ctrl_upper_bits();
      t_ctrl_mid_frame();
      @(negedge clk);
      sys_bit = 1'b0;
      t_rx_down_framed();
      t_rx_clear_and_up_unframed();
      t_rx_errors();
      t_rx_all_ones();
      @(negedge clk);
      finish_run();
   end

endmodule